// File: doc/BRIEF.md
# Event-Sourced Prescaled Interrupt Counter

This block counts events from one of four selectable sources and raises an interrupt when its main counter rolls over. Each accepted event steps a prescaler. When the prescaler rolls over within its configured width, the main counter steps once in the same direction. The sources are the CPU clock cycle, a rising edge on a graphics address line, a graphics memory read, and a CPU write. Each arrives as a single-cycle pulse that has already been edge-detected.

Software programs the block through a small write port: a register index plus a data byte. A mode register picks the source, the prescaler width and the count direction. A prescaler load is combined (XOR) with a separately written mask value. The same mask can also serve as the prescaler's wrap mask. A counter load register, plus enable and disable strobes, complete the interface. The interrupt output is a level. It stays high until software writes the disable register.

Top module: `evt_irq_counter`

## Requirements
- R1: After reset the interrupt output is low, and mode, mask, prescaler, counter and enable are all zero. With mode zero the counter is stopped, so events cause no interrupt.
- R2: Mode bits [1:0] pick the event source: 0 CPU cycle pulse, 1 graphics address rising-edge pulse, 2 graphics read pulse, 3 CPU write pulse. Pulses on unselected sources have no effect.
- R3: Mode bit 2 sets the prescaler width: set gives 3 bits (the counter steps once per 8 events), clear gives the full 8 bits (once per 256 events).
- R4: Mode bits [7:6] set the direction: 2'b01 counts up, 2'b10 counts down, and 2'b00 or 2'b11 stops both prescaler and counter.
- R5: A write to index 1 loads the prescaler with the written byte XOR the mask register, where index 3 holds the mask.
- R6: When mode bit 3 is set, the mask register replaces the width from mode bit 2 as the prescaler wrap mask. The prescaler then wraps when its masked bits are all ones (up) or all zeros (down) as an event arrives.
- R7: A write to index 2 loads the main counter with the written byte. Index 0 writes the mode register.
- R8: The interrupt output goes high on the clock edge where the counter steps past its terminal value (0xFF to 0x00 up, 0x00 to 0xFF down) while enable is set. It then stays high.
- R9: A write to index 4 sets enable. A write to index 5 clears both enable and the interrupt output.
- R10: A rollover while enable is clear leaves the interrupt output low.
- R11: A cycle with a prescaler or counter load write drops that cycle's event: the load value is kept and nothing else steps.
- R12: Writes to indices 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 3 | Register index of the write |
| wr_data | input | 8 | Write data |
| ev_cpu_cycle | input | 1 | CPU cycle event pulse (source 0) |
| ev_gfx_addr_rise | input | 1 | Graphics address line rising-edge pulse (source 1) |
| ev_gfx_read | input | 1 | Graphics read pulse (source 2) |
| ev_cpu_write | input | 1 | CPU write event pulse (source 3) |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit data path and counter, and a 3-bit narrow prescaler. With the narrow prescaler, a counter preloaded near its terminal value rolls over within a few dozen events. This keeps rollover, hold and disable cases frequent under random stimulus. A directed run of 256 events covers the full-width prescaler. Random mask values combined with mode bit 3 exercise irregular wrap masks, including a zero mask that wraps on every event.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

  localparam int unsigned IDX_W = 3;

  typedef enum logic [IDX_W-1:0] {
    IDX_MODE = 3'd0,
    IDX_PRE  = 3'd1,
    IDX_CNT  = 3'd2,
    IDX_MASK = 3'd3,
    IDX_EN   = 3'd4,
    IDX_DIS  = 3'd5
  } reg_idx_e;

  typedef enum logic [1:0] {
    DIR_STOP = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DOWN = 2'd2
  } dir_e;

  // Mode field positions
  localparam int unsigned MODE_SRC_LO = 0;
  localparam int unsigned MODE_NARROW = 2;
  localparam int unsigned MODE_ALT    = 3;
  localparam int unsigned MODE_DIR_LO = 6;

  function automatic dir_e decode_dir(input logic [1:0] f);
    case (f)
      2'b01:   decode_dir = DIR_UP;
      2'b10:   decode_dir = DIR_DOWN;
      default: decode_dir = DIR_STOP;
    endcase
  endfunction

endpackage

// File: rtl/evt_irq_rst_sync.sv
module evt_irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/evt_irq_regs.sv
module evt_irq_regs
  import evt_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] mode_q,
  output logic [DATA_W-1:0] mask_q,
  output logic              en_q,
  output logic              pre_ld,
  output logic [DATA_W-1:0] pre_ld_val,
  output logic              cnt_ld,
  output logic              dis_stb
);
  logic              mode_we;
  logic              mask_we;
  logic              en_we;
  logic [DATA_W-1:0] mode_d;
  logic [DATA_W-1:0] mask_d;
  logic              en_d;

  // Write decode
  always_comb begin
    mode_we = wr_en && (wr_idx == IDX_MODE);
    mask_we = wr_en && (wr_idx == IDX_MASK);
    en_we   = wr_en && (wr_idx == IDX_EN);
    pre_ld  = wr_en && (wr_idx == IDX_PRE);
    cnt_ld  = wr_en && (wr_idx == IDX_CNT);
    dis_stb = wr_en && (wr_idx == IDX_DIS);
    pre_ld_val = wr_data ^ mask_q;
  end

  // Next state
  always_comb begin
    mode_d = mode_q;
    mask_d = mask_q;
    en_d   = en_q;
    if (mode_we) mode_d = wr_data;
    if (mask_we) mask_d = wr_data;
    if (en_we)        en_d = 1'b1;
    else if (dis_stb) en_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      mask_q <= '0;
      en_q   <= 1'b0;
    end else begin
      mode_q <= mode_d;
      mask_q <= mask_d;
      en_q   <= en_d;
    end
  end
endmodule

// File: rtl/evt_irq_src_sel.sv
module evt_irq_src_sel #(
  parameter int unsigned N_SRC = 4,
  localparam int unsigned SEL_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] ev,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [N_SRC-1:0] gated;

  // One gate per source, enabled only when that source is selected
  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign gated[g] = ev[g] && (sel == SEL_W'(g));
  end

  assign tick = |gated;
endmodule

// File: rtl/evt_irq_prescaler.sv
module evt_irq_prescaler
  import evt_irq_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned NARROW_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [DATA_W-1:0] ld_val,
  input  logic              step,
  input  dir_e              dir,
  input  logic              narrow,
  input  logic              alt,
  input  logic [DATA_W-1:0] mask,
  output logic [DATA_W-1:0] pre_q,
  output logic              wrap
);
  localparam logic [DATA_W-1:0] NARROW_MASK = DATA_W'((1 << NARROW_W) - 1);

  logic [DATA_W-1:0] wmask;
  logic [DATA_W-1:0] masked;
  logic              at_term;
  logic [DATA_W-1:0] pre_d;

  always_comb begin
    if (alt)         wmask = mask;
    else if (narrow) wmask = NARROW_MASK;
    else             wmask = '1;
    masked  = pre_q & wmask;
    at_term = (dir == DIR_DOWN) ? (masked == '0) : (masked == wmask);
    wrap    = step && at_term;
  end

  always_comb begin
    pre_d = pre_q;
    if (ld) begin
      pre_d = ld_val;
    end else if (step) begin
      if (dir == DIR_DOWN) pre_d = pre_q - 1'b1;
      else                 pre_d = pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/evt_irq_main_cnt.sv
module evt_irq_main_cnt
  import evt_irq_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             adv,
  input  dir_e             dir,
  input  logic             en,
  input  logic             dis,
  output logic [CNT_W-1:0] cnt_q,
  output logic             irq
);
  logic [CNT_W-1:0] cnt_d;
  logic             at_term;
  logic             hit;
  logic             irq_d;

  always_comb begin
    at_term = (dir == DIR_DOWN) ? (cnt_q == '0) : (cnt_q == '1);
    hit     = adv && at_term;
  end

  always_comb begin
    cnt_d = cnt_q;
    if (ld) begin
      cnt_d = ld_val;
    end else if (adv) begin
      if (dir == DIR_DOWN) cnt_d = cnt_q - 1'b1;
      else                 cnt_d = cnt_q + 1'b1;
    end
  end

  always_comb begin
    irq_d = irq;
    if (dis)            irq_d = 1'b0;
    else if (hit && en) irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq   <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      irq   <= irq_d;
    end
  end
endmodule

// File: rtl/evt_irq_counter.sv
module evt_irq_counter
  import evt_irq_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned NARROW_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ev_cpu_cycle,
  input  logic              ev_gfx_addr_rise,
  input  logic              ev_gfx_read,
  input  logic              ev_cpu_write,
  output logic              irq
);
  localparam int unsigned N_SRC = 4;
  localparam int unsigned SEL_W = $clog2(N_SRC);

  logic              rst_sync_n;
  logic [DATA_W-1:0] mode_q;
  logic [DATA_W-1:0] mask_q;
  logic              en_q;
  logic              pre_ld;
  logic [DATA_W-1:0] pre_ld_val;
  logic              cnt_ld;
  logic              dis_stb;
  logic [N_SRC-1:0]  ev_vec;
  logic              tick;
  logic              step;
  dir_e              dir;
  logic [DATA_W-1:0] pre_q;
  logic              pre_wrap;
  logic [DATA_W-1:0] cnt_q;

  evt_irq_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  evt_irq_regs #(.DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .mode_q     (mode_q),
    .mask_q     (mask_q),
    .en_q       (en_q),
    .pre_ld     (pre_ld),
    .pre_ld_val (pre_ld_val),
    .cnt_ld     (cnt_ld),
    .dis_stb    (dis_stb)
  );

  assign ev_vec = {ev_cpu_write, ev_gfx_read, ev_gfx_addr_rise, ev_cpu_cycle};

  evt_irq_src_sel #(.N_SRC(N_SRC)) u_src_sel (
    .ev   (ev_vec),
    .sel  (mode_q[MODE_SRC_LO +: SEL_W]),
    .tick (tick)
  );

  // Event acceptance: running direction and no load write this cycle
  always_comb begin
    dir  = decode_dir(mode_q[MODE_DIR_LO +: 2]);
    step = tick && (dir != DIR_STOP) && !pre_ld && !cnt_ld;
  end

  evt_irq_prescaler #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .ld     (pre_ld),
    .ld_val (pre_ld_val),
    .step   (step),
    .dir    (dir),
    .narrow (mode_q[MODE_NARROW]),
    .alt    (mode_q[MODE_ALT]),
    .mask   (mask_q),
    .pre_q  (pre_q),
    .wrap   (pre_wrap)
  );

  evt_irq_main_cnt #(.CNT_W(DATA_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .ld     (cnt_ld),
    .ld_val (wr_data),
    .adv    (pre_wrap),
    .dir    (dir),
    .en     (en_q),
    .dis    (dis_stb),
    .cnt_q  (cnt_q),
    .irq    (irq)
  );
endmodule

// File: rtl/evt_irq_counter_chk.sv
module evt_irq_counter_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [2:0]        wr_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] mode_q,
  input logic [DATA_W-1:0] mask_q,
  input logic [DATA_W-1:0] pre_q,
  input logic [DATA_W-1:0] cnt_q,
  input logic              en_q,
  input logic              tick,
  input logic              irq
);
  logic stopped;
  logic any_ld;
  assign stopped = (mode_q[7:6] == 2'b00) || (mode_q[7:6] == 2'b11);
  assign any_ld  = wr_en && (wr_idx == 3'd1 || wr_idx == 3'd2);

  a_r9_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 3'd5) |=> (!irq && !en_q));

  a_r8_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(wr_en && wr_idx == 3'd5)) |=> irq);

  a_r10_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !en_q) |=> !irq);

  a_r4_stop_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped && !any_ld) |=> ($stable(cnt_q) && $stable(pre_q)));

  a_r2_no_tick_no_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !any_ld) |=> $stable(pre_q));

  a_r7_cnt_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 3'd2) |=> (cnt_q == $past(wr_data)));

  a_r5_pre_load_xor: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 3'd1) |=> (pre_q == ($past(wr_data) ^ $past(mask_q))));

  a_r11_load_blocks_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 3'd1) |=> $stable(cnt_q));
endmodule

bind evt_irq_counter evt_irq_counter_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .wr_en   (wr_en),
  .wr_idx  (wr_idx),
  .wr_data (wr_data),
  .mode_q  (mode_q),
  .mask_q  (mask_q),
  .pre_q   (pre_q),
  .cnt_q   (cnt_q),
  .en_q    (en_q),
  .tick    (tick),
  .irq     (irq)
);

// File: tb/evt_irq_counter_tb.sv
module evt_irq_counter_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [2:0] wr_idx;
  logic [7:0] wr_data;
  logic [3:0] ev;
  logic       irq;

  int n_checks;
  int n_fail;
  bit done;
  string cur_req;

  // Reference state
  logic [7:0] m_mode, m_mask, m_pre, m_cnt;
  logic       m_en, m_irq;

  evt_irq_counter u_dut (
    .clk              (clk),
    .rst_n            (rst_n),
    .wr_en            (wr_en),
    .wr_idx           (wr_idx),
    .wr_data          (wr_data),
    .ev_cpu_cycle     (ev[0]),
    .ev_gfx_addr_rise (ev[1]),
    .ev_gfx_read      (ev[2]),
    .ev_cpu_write     (ev[3]),
    .irq              (irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] wrap_mask(input logic [7:0] mode, input logic [7:0] mask);
    if (mode[3])      return mask;
    else if (mode[2]) return 8'h07;
    else              return 8'hFF;
  endfunction

  task automatic model_step(input bit we, input logic [2:0] idx, input logic [7:0] d,
                            input logic [3:0] e);
    logic [1:0] dirf;
    bit up, down, acc, pw, hit;
    logic [7:0] wm;
    dirf = m_mode[7:6];
    up   = (dirf == 2'b01);
    down = (dirf == 2'b10);
    acc  = e[m_mode[1:0]] && (up || down) && !(we && (idx == 3'd1 || idx == 3'd2));
    wm   = wrap_mask(m_mode, m_mask);
    pw   = acc && (up ? ((m_pre & wm) == wm) : ((m_pre & wm) == 8'h00));
    hit  = pw && (up ? (m_cnt == 8'hFF) : (m_cnt == 8'h00));
    if (we && idx == 3'd5)   m_irq = 1'b0;
    else if (hit && m_en)    m_irq = 1'b1;
    if (we && idx == 3'd1)   m_pre = d ^ m_mask;
    else if (acc)            m_pre = up ? m_pre + 8'd1 : m_pre - 8'd1;
    if (we && idx == 3'd2)   m_cnt = d;
    else if (pw)             m_cnt = up ? m_cnt + 8'd1 : m_cnt - 8'd1;
    if (we && idx == 3'd0)   m_mode = d;
    if (we && idx == 3'd3)   m_mask = d;
    if (we && idx == 3'd4)   m_en = 1'b1;
    else if (we && idx == 3'd5) m_en = 1'b0;
  endtask

  task automatic check_irq();
    n_checks++;
    if (irq !== m_irq) begin
      n_fail++;
      $display("FAIL %s: irq actual=%0b expected=%0b at %0t", cur_req, irq, m_irq, $time);
    end
  endtask

  // One clock: drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(input bit we, input logic [2:0] idx, input logic [7:0] d,
                     input logic [3:0] e);
    wr_en = we; wr_idx = idx; wr_data = d; ev = e;
    @(posedge clk);
    model_step(we, idx, d, e);
    @(negedge clk);
    wr_en = 1'b0; ev = 4'h0;
    check_irq();
  endtask

  task automatic wr(input logic [2:0] idx, input logic [7:0] d);
    cyc(1'b1, idx, d, 4'h0);
  endtask

  task automatic pulses(input int n, input logic [3:0] e);
    for (int i = 0; i < n; i++) cyc(1'b0, 3'd0, 8'h00, e);
  endtask

  task automatic expect_irq(input logic exp, input string req);
    n_checks++;
    if (irq !== exp) begin
      n_fail++;
      $display("FAIL %s: irq actual=%0b expected=%0b at %0t", req, irq, exp, $time);
    end
  endtask

  task automatic clean(input logic [7:0] mode);
    wr(3'd5, 8'h00);
    wr(3'd3, 8'h00);
    wr(3'd0, mode);
    wr(3'd1, 8'h00);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : main
    n_checks = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_data = '0; ev = '0;
    m_mode = 0; m_mask = 0; m_pre = 0; m_cnt = 0; m_en = 0; m_irq = 0;
    void'($urandom(32'd20240611));
    cur_req = "R1";
    repeat (3) @(negedge clk);
    expect_irq(1'b0, "R1");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    expect_irq(1'b0, "R1");

    // R1: mode zero is stopped even with enable and terminal count
    wr(3'd4, 8'h00);
    wr(3'd2, 8'hFF);
    pulses(300, 4'hF);
    expect_irq(1'b0, "R1");

    // R3 narrow width, up: 8 events to rollover from FF
    cur_req = "R3";
    clean(8'h44);
    wr(3'd2, 8'hFF); wr(3'd4, 8'h00);
    pulses(7, 4'h1);
    expect_irq(1'b0, "R3");
    pulses(1, 4'h1);
    expect_irq(1'b1, "R3");

    // R9 disable clears irq and enable
    cur_req = "R9";
    wr(3'd5, 8'h00);
    expect_irq(1'b0, "R9");
    wr(3'd2, 8'hFF);
    pulses(8, 4'h1);
    expect_irq(1'b0, "R9");

    // R10 rollover with enable clear
    cur_req = "R10";
    pulses(64, 4'h1);
    expect_irq(1'b0, "R10");

    // R3 full width: 256 events
    cur_req = "R3";
    clean(8'h40);
    wr(3'd2, 8'hFF); wr(3'd4, 8'h00);
    pulses(255, 4'h1);
    expect_irq(1'b0, "R3");
    pulses(1, 4'h1);
    expect_irq(1'b1, "R3");

    // R8 holds while further events arrive
    cur_req = "R8";
    pulses(40, 4'h1);
    expect_irq(1'b1, "R8");

    // R2 source select: graphics address source, others ignored
    cur_req = "R2";
    clean(8'h45);
    wr(3'd2, 8'hFF); wr(3'd4, 8'h00);
    pulses(40, 4'hD);
    expect_irq(1'b0, "R2");
    pulses(8, 4'h2);
    expect_irq(1'b1, "R2");
    clean(8'h47);
    wr(3'd2, 8'hFF); wr(3'd4, 8'h00);
    pulses(8, 4'h8);
    expect_irq(1'b1, "R2");

    // R4 down: from 00 with narrow prescaler, pre=0 wraps at first event
    cur_req = "R4";
    clean(8'h86);
    wr(3'd2, 8'h00); wr(3'd4, 8'h00);
    pulses(1, 4'h4);
    expect_irq(1'b1, "R4");
    clean(8'hC4);
    wr(3'd2, 8'hFF); wr(3'd4, 8'h00);
    pulses(50, 4'h1);
    expect_irq(1'b0, "R4");

    // R5 prescaler load XOR mask: 0x02^0x05=0x07 so first event wraps
    cur_req = "R5";
    clean(8'h44);
    wr(3'd3, 8'h05); wr(3'd1, 8'h02);
    wr(3'd2, 8'hFF); wr(3'd4, 8'h00);
    pulses(1, 4'h1);
    expect_irq(1'b1, "R5");

    // R6 mask as wrap mask: mask 0x01 wraps every 2 events
    cur_req = "R6";
    clean(8'h48);
    wr(3'd3, 8'h01);
    wr(3'd2, 8'hFE); wr(3'd4, 8'h00);
    pulses(3, 4'h1);
    expect_irq(1'b0, "R6");
    pulses(1, 4'h1);
    expect_irq(1'b1, "R6");

    // R7 counter load moves the rollover point
    cur_req = "R7";
    clean(8'h44);
    wr(3'd2, 8'hFE); wr(3'd4, 8'h00);
    pulses(15, 4'h1);
    expect_irq(1'b0, "R7");
    pulses(1, 4'h1);
    expect_irq(1'b1, "R7");

    // R11 load with simultaneous event drops the event
    cur_req = "R11";
    clean(8'h44);
    wr(3'd4, 8'h00);
    cyc(1'b1, 3'd1, 8'h07, 4'h1);
    cyc(1'b1, 3'd2, 8'hFF, 4'h1);
    expect_irq(1'b0, "R11");
    pulses(1, 4'h1);
    expect_irq(1'b1, "R11");

    // R12 unused indices change nothing
    cur_req = "R12";
    clean(8'h44);
    wr(3'd2, 8'hFF); wr(3'd4, 8'h00);
    wr(3'd6, 8'h00); wr(3'd7, 8'hFF);
    pulses(7, 4'h1);
    expect_irq(1'b0, "R12");
    pulses(1, 4'h1);
    expect_irq(1'b1, "R12");

    // Random phase (R8 / R2 / R4 mix)
    cur_req = "R8";
    for (int i = 0; i < 20000; i++) begin
      bit we;
      logic [2:0] idx;
      logic [7:0] d;
      we  = (($urandom % 10) == 0);
      idx = 3'($urandom % 8);
      d   = 8'($urandom);
      if (idx == 3'd2) d = ($urandom % 2) ? (8'hFC | 8'($urandom % 4)) : 8'($urandom % 4);
      if (idx == 3'd0 && ($urandom % 2)) d[2] = 1'b1;
      if (idx == 3'd5 && ($urandom % 3) != 0) we = 1'b0;
      cyc(we, idx, d, 4'($urandom));
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule